// File: doc/BRIEF.md
# Trigger Source Selection and Busy Control

This block turns several asynchronous detector trigger pulses into one raw trigger and one live trigger for a data acquisition system. It has five sources: a primary singles input, a secondary singles input, a coincidence of primary and secondary, and two independent external inputs. The primary and secondary singles paths each pass through their own programmable downscaler. A mask word selects which sources may contribute, and any number of them can be enabled together. The raw trigger is the OR of the enabled sources after downscaling.

A busy flag is set by every raw trigger and stays set until the readout side signals completion on a clear-busy input. The live trigger is the raw trigger with two vetoes applied: busy set, or the run-enable bit low. To measure dead time, the block also takes a free-running pulser and outputs two copies of it. One copy is unvetoed. The other is vetoed by the same busy and run-enable conditions. When a primary pulse arrives during a run, a programmable window opens. If no live trigger appears before the window closes, the block emits a fast-clear pulse so that a charge digitizer already gated by that pulse can be discarded.

All asynchronous inputs are synchronised and edge-detected inside the block. Reset is active low and asynchronous on assertion. The reset input must already be released in step with the clock.

Top module: `trg_select_busy`

## Requirements
- R1: Each rising edge on a source, pulser or clear-busy input produces exactly one internal single-cycle event, however long the input stays high. A raw trigger caused by an input that rises between two clock edges appears in the cycle after the third rising clock edge that follows, and is one cycle wide.
- R2: The primary singles path has a downscale factor N. It passes the N-th, 2N-th, 3N-th pulse and so on. A factor of 0 or 1 passes every pulse.
- R3: The secondary singles path has its own downscale factor with the same rule, independent of the primary factor.
- R4: The coincidence source fires once when the primary and secondary inputs are both high, counted from the moment the second of the two rises. It is not downscaled.
- R5: Mask bit 0 enables primary, bit 1 secondary, bit 2 coincidence, bit 3 external A and bit 4 external B. A source whose bit is 0 never causes a raw trigger. Simultaneous enabled events produce a single one-cycle raw trigger.
- R6: Busy is set by every raw trigger and stays set until a clear-busy event. If a clear-busy event and a raw trigger fall in the same cycle, busy ends up set.
- R7: The live trigger equals the raw trigger only while busy was clear and run enable is high. Raw triggers still occur, and still set busy, while run enable is low.
- R8: The unvetoed pulser output pulses once for every pulser rising edge. The vetoed pulser output pulses only when busy is clear and run enable is high.
- R9: While run enable is high, each primary event (taken before downscaling) opens a window of W cycles, with W = 0 treated as 1. If no live trigger appears within the window, a one-cycle fast clear is issued W cycles after the window opens. A live trigger inside the window cancels it.
- R10: Reset drives every output low, clears busy, drops any open fast-clear window and restarts both downscaler counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| src_prim_i | input | 1 | Primary singles source, asynchronous |
| src_sec_i | input | 1 | Secondary singles source, asynchronous |
| src_ext_a_i | input | 1 | External source A, asynchronous |
| src_ext_b_i | input | 1 | External source B, asynchronous |
| pulser_i | input | 1 | Free-running reference pulser, asynchronous |
| clr_busy_i | input | 1 | Readout-complete strobe that clears busy, asynchronous |
| run_en_i | input | 1 | Run enable, synchronous to clk |
| src_mask_i | input | 5 | Source enable mask (see R5) |
| prim_div_i | input | DIV_W | Primary downscale factor |
| sec_div_i | input | DIV_W | Secondary downscale factor |
| fc_win_i | input | WIN_W | Fast-clear window length in cycles |
| raw_trig_o | output | 1 | Raw trigger pulse |
| live_trig_o | output | 1 | Live trigger pulse |
| busy_o | output | 1 | Busy flag |
| pulser_raw_o | output | 1 | Unvetoed pulser copy |
| pulser_live_o | output | 1 | Pulser copy vetoed by busy and run enable |
| fast_clr_o | output | 1 | Fast-clear pulse |

## Verification
An input that rises between edges k-1 and k affects the raw trigger, live trigger, busy and pulser outputs after edge k+2. A fast clear arrives after edge k+2+W, or after edge k+3 when W is 0. The bench changes every input half a cycle away from the rising edge and samples on falling edges. Exact-cycle checks count falling edges from the stimulus to those edges. Pulse-count checks run a bench tally of output pulses over a settling interval longer than the largest window in use, so they cannot depend on when inside that interval a pulse lands.

// File: rtl/trg_pkg.sv
package trg_pkg;
  // Enabled-source positions inside the selection mask
  localparam int SRC_PRIM  = 0;
  localparam int SRC_SEC   = 1;
  localparam int SRC_COINC = 2;
  localparam int SRC_EXTA  = 3;
  localparam int SRC_EXTB  = 4;
  localparam int N_SRC     = 5;

  // Positions of the synchronised input events
  localparam int IN_PRIM   = 0;
  localparam int IN_SEC    = 1;
  localparam int IN_EXTA   = 2;
  localparam int IN_EXTB   = 3;
  localparam int IN_PULSER = 4;
  localparam int IN_CLR    = 5;
  localparam int IN_COINC  = 6;
  localparam int N_IN      = 7;
endpackage

// File: rtl/trg_edge_sync.sv
module trg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, lvl;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  assign lvl     = sh_q[STAGES-1];
  assign pulse_o = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= lvl;
    end
  end

  // R1: an edge event never lasts beyond one cycle
  p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/trg_downscale.sv
module trg_downscale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic [DIV_W-1:0] factor_i,
  output logic             pass_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    last   = (factor_i <= DIV_W'(1)) || (cnt_q >= factor_i - DIV_W'(1));
    pass_o = pulse_i & last;
    cnt_d  = cnt_q;
    if (pulse_i) cnt_d = last ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (pulse_i) cnt_q <= cnt_d;
  end

  // R2/R3: the count only moves on an input event
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_i |=> $stable(cnt_q));
endmodule

// File: rtl/trg_fastclr.sv
module trg_fastclr #(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             live_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             fc_o
);
  logic             armed_q, armed_d, fc_q, fc_d;
  logic [WIN_W-1:0] cnt_q, cnt_d, win_eff;

  assign win_eff = (win_i == '0) ? WIN_W'(1) : win_i;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fc_d    = 1'b0;
    if (armed_q) begin
      if (live_i) begin
        armed_d = 1'b0;
      end else if (cnt_q == WIN_W'(1)) begin
        fc_d    = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - WIN_W'(1);
      end
    end
    if (arm_i) begin
      armed_d = 1'b1;
      cnt_d   = win_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      fc_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      fc_q    <= fc_d;
    end
  end

  assign fc_o = fc_q;

  // R9: a fast clear is one cycle wide and only closes an open window
  p_fc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fc_q |=> !fc_q);
  p_fc_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fc_q |-> $past(armed_q));
endmodule

// File: rtl/trg_select_busy.sv
module trg_select_busy
  import trg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 16,
  parameter int WIN_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_prim_i,
  input  logic             src_sec_i,
  input  logic             src_ext_a_i,
  input  logic             src_ext_b_i,
  input  logic             pulser_i,
  input  logic             clr_busy_i,
  input  logic             run_en_i,
  input  logic [4:0]       src_mask_i,
  input  logic [DIV_W-1:0] prim_div_i,
  input  logic [DIV_W-1:0] sec_div_i,
  input  logic [WIN_W-1:0] fc_win_i,
  output logic             raw_trig_o,
  output logic             live_trig_o,
  output logic             busy_o,
  output logic             pulser_raw_o,
  output logic             pulser_live_o,
  output logic             fast_clr_o
);
  logic [N_IN-1:0]  in_vec, ev;
  logic [1:0]       ds_in, ds_out;
  logic [DIV_W-1:0] ds_fac [2];
  logic [N_SRC-1:0] src_ev;
  logic raw_d, live_d, busy_d, pl_d;
  logic raw_q, live_q, busy_q, pr_q, pl_q;

  always_comb begin
    in_vec            = '0;
    in_vec[IN_PRIM]   = src_prim_i;
    in_vec[IN_SEC]    = src_sec_i;
    in_vec[IN_EXTA]   = src_ext_a_i;
    in_vec[IN_EXTB]   = src_ext_b_i;
    in_vec[IN_PULSER] = pulser_i;
    in_vec[IN_CLR]    = clr_busy_i;
    in_vec[IN_COINC]  = src_prim_i & src_sec_i;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    trg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (in_vec[i]),
      .pulse_o(ev[i])
    );
  end

  assign ds_in     = {ev[IN_SEC], ev[IN_PRIM]};
  assign ds_fac[0] = prim_div_i;
  assign ds_fac[1] = sec_div_i;

  for (genvar j = 0; j < 2; j++) begin : g_div
    trg_downscale #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (ds_in[j]),
      .factor_i(ds_fac[j]),
      .pass_o  (ds_out[j])
    );
  end

  always_comb begin
    src_ev            = '0;
    src_ev[SRC_PRIM]  = ds_out[0];
    src_ev[SRC_SEC]   = ds_out[1];
    src_ev[SRC_COINC] = ev[IN_COINC];
    src_ev[SRC_EXTA]  = ev[IN_EXTA];
    src_ev[SRC_EXTB]  = ev[IN_EXTB];
  end

  always_comb begin
    raw_d  = |(src_ev & src_mask_i);
    live_d = raw_d & ~busy_q & run_en_i;
    pl_d   = ev[IN_PULSER] & ~busy_q & run_en_i;
    busy_d = busy_q;
    if (ev[IN_CLR]) busy_d = 1'b0;
    if (raw_d)      busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      live_q <= 1'b0;
      busy_q <= 1'b0;
      pr_q   <= 1'b0;
      pl_q   <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      live_q <= live_d;
      busy_q <= busy_d;
      pr_q   <= ev[IN_PULSER];
      pl_q   <= pl_d;
    end
  end

  trg_fastclr #(.WIN_W(WIN_W)) u_fc (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (ev[IN_PRIM] & run_en_i),
    .live_i(live_q),
    .win_i (fc_win_i),
    .fc_o  (fast_clr_o)
  );

  assign raw_trig_o    = raw_q;
  assign live_trig_o   = live_q;
  assign busy_o        = busy_q;
  assign pulser_raw_o  = pr_q;
  assign pulser_live_o = pl_q;

  // R7: a live trigger is always accompanied by a raw trigger
  p_live_in_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> raw_q);
  // R7: after a live trigger busy blocks the very next cycle
  p_live_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> !live_q);
  // R6: a raw trigger always leaves busy set
  p_raw_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |-> busy_q);
  // R6: busy only rises together with a raw trigger
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> raw_q);
  // R8: the vetoed pulser is a subset of the free-running copy
  p_pulser_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulser_live_o |-> pulser_raw_o);
endmodule

// File: tb/trg_select_busy_tb.sv
module trg_select_busy_tb;
  localparam int DIV_W = 16;
  localparam int WIN_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic prim, sec, exta, extb, pulser, clr, run;
  logic [4:0]       mask;
  logic [DIV_W-1:0] pdiv, sdiv;
  logic [WIN_W-1:0] win;
  logic raw, live, busy, prw, plv, fc;

  int n_chk = 0, n_fail = 0;
  int c_raw = 0, c_live = 0, c_pr = 0, c_pl = 0, c_fc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trg_select_busy #(.DIV_W(DIV_W), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_prim_i(prim), .src_sec_i(sec), .src_ext_a_i(exta), .src_ext_b_i(extb),
    .pulser_i(pulser), .clr_busy_i(clr), .run_en_i(run),
    .src_mask_i(mask), .prim_div_i(pdiv), .sec_div_i(sdiv), .fc_win_i(win),
    .raw_trig_o(raw), .live_trig_o(live), .busy_o(busy),
    .pulser_raw_o(prw), .pulser_live_o(plv), .fast_clr_o(fc)
  );

  always @(negedge clk) if (rst_n) begin
    if (raw)  c_raw++;
    if (live) c_live++;
    if (prw)  c_pr++;
    if (plv)  c_pl++;
    if (fc)   c_fc++;
  end

  // fields: run, mask[4:0], pattern {pulser,extb,exta,sec,prim},
  //         expected {raw, live, pulser raw, pulser live, fast clear, busy}
  localparam logic [16:0] TBL [0:11] = '{
    {1'b1, 5'b00001, 5'b00001, 6'b110001},  // R5 primary enabled
    {1'b1, 5'b00001, 5'b00010, 6'b000000},  // R5 secondary masked
    {1'b1, 5'b00010, 5'b00010, 6'b110001},  // R5 secondary enabled
    {1'b1, 5'b00100, 5'b00011, 6'b110001},  // R4 coincidence
    {1'b1, 5'b00100, 5'b00001, 6'b000010},  // R4/R9 lone primary
    {1'b1, 5'b01000, 5'b00100, 6'b110001},  // R5 external A
    {1'b1, 5'b10000, 5'b01000, 6'b110001},  // R5 external B
    {1'b1, 5'b01000, 5'b01000, 6'b000000},  // R5 external B masked
    {1'b0, 5'b00001, 5'b00001, 6'b100001},  // R7 run disabled
    {1'b1, 5'b00000, 5'b10000, 6'b001100},  // R8 pulser idle
    {1'b0, 5'b00000, 5'b10000, 6'b001000},  // R8 pulser, run off
    {1'b1, 5'b11111, 5'b01111, 6'b110001}   // R5 all at once
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic [4:0] pat);
    @(negedge clk);
    {pulser, extb, exta, sec, prim} = pat;
    idle(3);
    {pulser, extb, exta, sec, prim} = '0;
    idle(3);
  endtask

  task automatic clear_busy();
    @(negedge clk); clr = 1'b1;
    idle(3); clr = 1'b0;
    idle(3);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, l0, p0, q0, f0;
    rst_n = 1'b0; {prim, sec, exta, extb, pulser, clr} = '0;
    run = 1'b0; mask = '0; pdiv = 16'd1; sdiv = 16'd1; win = 12'd4;
    idle(4);
    // R10 reset state
    chk("R10 raw in reset", raw, 0);   chk("R10 live in reset", live, 0);
    chk("R10 busy in reset", busy, 0); chk("R10 fc in reset", fc, 0);
    chk("R10 pulser in reset", prw | plv, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); run = TBL[i][16]; mask = TBL[i][15:11];
      clear_busy();
      r0 = c_raw; l0 = c_live; p0 = c_pr; q0 = c_pl; f0 = c_fc;
      drive(TBL[i][10:6]);
      idle(12);
      chk($sformatf("R5/R7 raw vec%0d", i), c_raw - r0, int'(TBL[i][5]));
      chk($sformatf("R7 live vec%0d", i), c_live - l0, int'(TBL[i][4]));
      chk($sformatf("R8 pulser raw vec%0d", i), c_pr - p0, int'(TBL[i][3]));
      chk($sformatf("R8 pulser live vec%0d", i), c_pl - q0, int'(TBL[i][2]));
      chk($sformatf("R9 fast clear vec%0d", i), c_fc - f0, int'(TBL[i][1]));
      chk($sformatf("R6 busy vec%0d", i), busy, int'(TBL[i][0]));
    end

    // R1 exact latency and a held level
    @(negedge clk); run = 1'b1; mask = 5'b00001;
    clear_busy(); idle(2);
    r0 = c_raw;
    prim = 1'b1;
    idle(2); chk("R1 raw before third edge", raw, 0);
    idle(1); chk("R1 raw after third edge", raw, 1);
    idle(1); chk("R1 raw one cycle wide", raw, 0);
    idle(20); prim = 1'b0; idle(6);
    chk("R1 held level counts once", c_raw - r0, 1);

    // R6/R7/R8 while busy
    r0 = c_raw; l0 = c_live; p0 = c_pr; q0 = c_pl;
    drive(5'b00001); drive(5'b10000); idle(6);
    chk("R7 raw while busy", c_raw - r0, 1);
    chk("R7 live blocked by busy", c_live - l0, 0);
    chk("R8 pulser raw while busy", c_pr - p0, 1);
    chk("R8 pulser vetoed by busy", c_pl - q0, 0);
    chk("R6 busy held", busy, 1);

    // R6 set wins over a simultaneous clear
    r0 = c_raw; l0 = c_live;
    @(negedge clk); clr = 1'b1; prim = 1'b1;
    idle(3); clr = 1'b0; prim = 1'b0; idle(6);
    chk("R6 raw with clear", c_raw - r0, 1);
    chk("R6 live with clear", c_live - l0, 0);
    chk("R6 set wins", busy, 1);
    clear_busy();
    chk("R6 clear alone", busy, 0);

    // R2 primary downscale
    @(negedge clk); pdiv = 16'd3; r0 = c_raw;
    for (int k = 0; k < 7; k++) drive(5'b00001);
    idle(4); chk("R2 factor 3 over 7 pulses", c_raw - r0, 2);
    @(negedge clk); pdiv = 16'd0; r0 = c_raw;
    for (int k = 0; k < 3; k++) drive(5'b00001);
    idle(4); chk("R2 factor 0 passes all", c_raw - r0, 3);

    // R3 secondary downscale, independent of primary
    @(negedge clk); mask = 5'b00010; sdiv = 16'd2; pdiv = 16'd5; r0 = c_raw;
    for (int k = 0; k < 4; k++) drive(5'b00010);
    idle(4); chk("R3 factor 2 over 4 pulses", c_raw - r0, 2);
    @(negedge clk); mask = 5'b00011; pdiv = 16'd1; sdiv = 16'd4; r0 = c_raw;
    for (int k = 0; k < 2; k++) drive(5'b00001);
    idle(4); chk("R3 primary unaffected by secondary factor", c_raw - r0, 2);

    // R9 fast clear timing, W = 4 and W = 0
    @(negedge clk); mask = 5'b00000; win = 12'd4; idle(4);
    prim = 1'b1;
    idle(6); chk("R9 fc not yet at W", fc, 0);
    idle(1); chk("R9 fc at W", fc, 1);
    idle(1); chk("R9 fc one cycle", fc, 0);
    prim = 1'b0; idle(6);
    win = 12'd0;
    @(negedge clk); prim = 1'b1;
    idle(3); chk("R9 W0 fc not early", fc, 0);
    idle(1); chk("R9 W0 acts as 1", fc, 1);
    prim = 1'b0; idle(6);

    // R10 reset restarts the downscaler
    @(negedge clk); mask = 5'b00001; pdiv = 16'd3; win = 12'd4; r0 = c_raw;
    drive(5'b00001); drive(5'b00001); idle(4);
    chk("R2 no pass before third", c_raw - r0, 0);
    @(negedge clk); rst_n = 1'b0; idle(1);
    chk("R10 busy after reset", busy, 0);
    chk("R10 outputs after reset", raw | live | fc | prw | plv, 0);
    @(negedge clk); rst_n = 1'b1; idle(3);
    r0 = c_raw;
    drive(5'b00001); idle(4);
    chk("R10 count restarted", c_raw - r0, 0);
    drive(5'b00001); drive(5'b00001); idle(4);
    chk("R10 third pass after reset", c_raw - r0, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule